// File: doc/BRIEF.md
# Maskable Interrupt Arbiter with Software Promotion

This block picks one winner among the maskable interrupt requests of a small controller core. A fixed built-in order decides between simultaneous requests. Software can lift any single source above that order by writing its 4-bit code into a select register. The winner's code and a valid flag come out combinationally in the same cycle as the requests.

The select register can only be changed while the global interrupt-mask bit is set, which is the period in which maskable interrupts are inhibited. Writes made while that bit is clear are dropped. Reset loads the reserved code 0101. Every reserved code promotes the external IRQ line, so after reset IRQ is the top maskable source. The register value can be read back at all times.

Source codes, which are also the bit index of each source on the request vector:
- 0 timer overflow
- 1 pulse-accumulator overflow
- 2 pulse-accumulator edge
- 3 SPI done
- 4 SCI
- 5 reserved
- 6 IRQ
- 7 real-time tick
- 8 input capture 1

Top module: `irq_promote_arbiter`

## Requirements
- R1: A synchronous active-high reset loads the select register with 0101. After reset, with every source pending and the mask clear, the winner is IRQ (code 0110).
- R2: A one-cycle write pulse that is sampled at a clock edge while `imask_i` is 1 stores `wr_data_i`. The new value appears on `sel_o` after that edge.
- R3: A write pulse sampled while `imask_i` is 0 leaves `sel_o` unchanged.
- R4: `valid_o` is 1 only when `imask_i` is 0 and at least one non-reserved request bit is set. While `valid_o` is 0, `winner_o` is 0000.
- R5: When the source whose code is in the select register is pending, that source wins, whatever else is pending.
- R6: Select values 0101 and 1001 through 1111 promote IRQ (code 0110).
- R7: When the promoted source is not pending, the winner is the first pending source in this order: IRQ(6), real-time tick(7), input capture 1(8), timer overflow(0), PA overflow(1), PA edge(2), SPI(3), SCI(4).
- R8: Request bit 5 (reserved) never produces `valid_o` and never wins.
- R9: A write is accepted when `imask_i` goes from 0 to 1 in the same cycle as the write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 9 | Pending requests, bit n = source code n |
| imask_i | input | 1 | Global maskable-interrupt inhibit bit |
| wr_en_i | input | 1 | One-cycle write strobe for the select register |
| wr_data_i | input | 4 | Value to write into the select register |
| sel_o | output | 4 | Select register readback |
| valid_o | output | 1 | A maskable interrupt is to be taken |
| winner_o | output | 4 | Code of the winning source |

## Verification
The select register is the only state in the block. If it is wrong, the readback on `sel_o` shows it in the cycle after the write or the reset. The same error also changes `winner_o` at once, whenever the promoted source and a lower-ranked one are pending together. Errors in the fixed order or in the reserved-code decode show up only when the right pair of requests is pending with the mask clear. The vector table therefore pairs each promotion value with competing requests, and the directed tests cover mask-gated writes and the reset value.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
  localparam int CODE_W    = 4;
  localparam int NSRC      = 9;
  localparam int NORD      = 8;
  localparam int CODE_RSVD = 5;
  localparam int CODE_IRQ  = 6;

  // position p of the fixed order -> source code
  function automatic logic [CODE_W-1:0] order_code(input int p);
    if (p < 3) return CODE_W'(CODE_IRQ + p);
    else       return CODE_W'(p - 3);
  endfunction

  function automatic logic is_src(input int c);
    return (c < NSRC) && (c != CODE_RSVD);
  endfunction
endpackage

// File: rtl/ipa_select_reg.sv
module ipa_select_reg
  import ipa_pkg::*;
#(
  parameter int W         = CODE_W,
  parameter int RESET_VAL = CODE_RSVD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         imask,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)                sel_q <= W'(RESET_VAL);
    else if (wr_en && imask) sel_q <= wr_data;
  end

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> sel_q == W'(RESET_VAL));
  a_r2_write_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_en && imask) |=> sel_q == $past(wr_data));
  a_r3_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !imask) |=> $stable(sel_q));
endmodule

// File: rtl/ipa_promote_decode.sv
module ipa_promote_decode
  import ipa_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic [W-1:0] sel,
  output logic [W-1:0] prom
);
  always_comb begin
    if (is_src(int'(sel))) prom = sel;
    else                   prom = W'(CODE_IRQ);
  end
endmodule

// File: rtl/ipa_winner_arb.sv
module ipa_winner_arb
  import ipa_pkg::*;
#(
  parameter int W = CODE_W,
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         imask,
  input  logic [W-1:0] prom,
  output logic         valid,
  output logic [W-1:0] winner
);
  logic [N-1:0] req_eff;
  logic [W-1:0] fixed_pick;

  for (genvar i = 0; i < N; i++) begin : g_mask
    if (is_src(i)) begin : g_src
      assign req_eff[i] = req[i];
    end else begin : g_rsvd
      assign req_eff[i] = 1'b0;
    end
  end

  always_comb begin
    fixed_pick = '0;
    for (int p = NORD - 1; p >= 0; p--) begin
      if (req_eff[order_code(p)]) fixed_pick = order_code(p);
    end
  end

  assign valid  = !imask && (|req_eff);
  assign winner = !valid            ? '0   :
                  req_eff[prom]     ? prom : fixed_pick;

  a_r5_promoted_wins: assert property (@(posedge clk) disable iff (rst)
    (!imask && req[prom]) |-> winner == prom);
  a_r8_winner_pending: assert property (@(posedge clk) disable iff (rst)
    valid |-> (req[winner] && winner != W'(CODE_RSVD)));
endmodule

// File: rtl/irq_promote_arbiter.sv
module irq_promote_arbiter
  import ipa_pkg::*;
#(
  parameter int W         = CODE_W,
  parameter int N         = NSRC,
  parameter int RESET_SEL = CODE_RSVD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         imask_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] sel_o,
  output logic         valid_o,
  output logic [W-1:0] winner_o
);
  logic [W-1:0] prom;

  ipa_select_reg #(.W(W), .RESET_VAL(RESET_SEL)) u_sel (
    .clk(clk), .rst(rst), .imask(imask_i), .wr_en(wr_en_i),
    .wr_data(wr_data_i), .sel_q(sel_o)
  );

  ipa_promote_decode #(.W(W)) u_dec (.sel(sel_o), .prom(prom));

  ipa_winner_arb #(.W(W), .N(N)) u_arb (
    .clk(clk), .rst(rst), .req(req_i), .imask(imask_i), .prom(prom),
    .valid(valid_o), .winner(winner_o)
  );

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    imask_i |-> (!valid_o && winner_o == '0));
  a_r6_reserved_irq: assert property (@(posedge clk) disable iff (rst)
    (!imask_i && req_i[CODE_IRQ] && !is_src(int'(sel_o))) |-> winner_o == W'(CODE_IRQ));
endmodule

// File: tb/tb_irq_promote_arbiter.sv
module tb_irq_promote_arbiter;
  logic       clk = 0;
  logic       rst = 1;
  logic [8:0] req_i = '0;
  logic       imask_i = 1;
  logic       wr_en_i = 0;
  logic [3:0] wr_data_i = '0;
  logic [3:0] sel_o, winner_o;
  logic       valid_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_promote_arbiter dut (.*);

  // {sel, req, valid, winner}
  localparam logic [17:0] TBL [12] = '{
    {4'h5, 9'h1FF, 1'b1, 4'h6},  // R6 reset code promotes IRQ
    {4'h0, 9'h1FF, 1'b1, 4'h0},  // R5
    {4'h8, 9'h1FF, 1'b1, 4'h8},  // R5
    {4'h3, 9'h010, 1'b1, 4'h4},  // R7 lone SCI
    {4'h3, 9'h003, 1'b1, 4'h0},  // R7 TOF before PA ovf
    {4'h3, 9'h180, 1'b1, 4'h7},  // R7 RTI before IC1
    {4'hF, 9'h1C0, 1'b1, 4'h6},  // R6 1111 -> IRQ
    {4'h9, 9'h180, 1'b1, 4'h7},  // R6 IRQ promoted not pending -> R7
    {4'h4, 9'h020, 1'b0, 4'h0},  // R8 reserved bit alone
    {4'h4, 9'h000, 1'b0, 4'h0},  // R4 nothing pending
    {4'h2, 9'h01E, 1'b1, 4'h2},  // R5
    {4'h7, 9'h140, 1'b1, 4'h6}   // R7 RTI promoted, absent
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_sel(input logic [3:0] v, input logic mask);
    @(negedge clk);
    imask_i = mask; wr_en_i = 1; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 0; imask_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; imask_i = 0; req_i = 9'h1FF;
    #1;
    chk(sel_o == 4'h5, "R1 reset sel", sel_o, 5);
    chk(valid_o && winner_o == 4'h6, "R1 reset winner", winner_o, 6);

    foreach (TBL[i]) begin
      write_sel(TBL[i][17:14], 1'b1);
      chk(sel_o == TBL[i][17:14], "R2 readback", sel_o, TBL[i][17:14]);
      req_i = TBL[i][13:5];
      #1;
      chk(valid_o == TBL[i][4], $sformatf("R4 valid vec%0d", i), valid_o, TBL[i][4]);
      chk(winner_o == TBL[i][3:0], $sformatf("R5/R6/R7 winner vec%0d", i), winner_o, TBL[i][3:0]);
    end

    // R3: write with mask clear is dropped
    write_sel(4'h0, 1'b1);
    write_sel(4'h8, 1'b0);
    chk(sel_o == 4'h0, "R3 dropped write", sel_o, 0);
    req_i = 9'h101; #1;
    chk(winner_o == 4'h0, "R3 promotion kept", winner_o, 0);

    // R4: mask set hides pending requests
    @(negedge clk); imask_i = 1; req_i = 9'h1FF; #1;
    chk(!valid_o && winner_o == 4'h0, "R4 masked", {valid_o, winner_o}, 0);

    // R9: mask rises in same cycle as write
    @(negedge clk); imask_i = 0;
    @(negedge clk); imask_i = 1; wr_en_i = 1; wr_data_i = 4'h7;
    @(negedge clk); wr_en_i = 0; imask_i = 0; req_i = 9'h1C1; #1;
    chk(sel_o == 4'h7, "R9 same-cycle write", sel_o, 7);
    chk(winner_o == 4'h7, "R9 winner", winner_o, 7);

    // R1: reset mid-run restores 0101
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    chk(sel_o == 4'h5 && winner_o == 4'h6, "R1 re-reset", {sel_o, winner_o}, 8'h56);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule